// File: doc/BRIEF.md
# Brushless Motor Commutation Generator

The block turns a 12-bit absolute shaft angle into three square-wave commutation lines, U, V and W, for a brushless motor. The three lines are offset from one another by 120 electrical degrees. A two-bit pole setting chooses the number of electrical periods in one mechanical turn: one period for a two-pole motor, two for four poles and four for eight poles. The electrical angle is the mechanical angle shifted left by 0, 1 or 2 bits, and only the low 12 bits are kept.

Each electrical period is split into six sectors of 60 degrees. A small state machine holds the current sector. It leaves its idle state on the first valid angle sample and moves to the state for the sector that sample falls in. Once that first valid sample has been taken, every later valid sample loads the matching sector state. When the valid flag is low, the machine stays in the state it is in. The three lines are decoded from the state register, so they appear one clock after the sample.

States: `ST_IDLE`, which holds all lines low, and `ST_S0` to `ST_S5`, one per sector. Transitions:
- *first-lock*: `ST_IDLE` to `ST_Sn` on the first valid sample.
- *step*: `ST_Sx` to `ST_Sn` on any later valid sample.
- *hold*: the machine keeps its state while valid is low.

Top module: `mcg_commutator`

## Requirements
- R1: After reset and until the first cycle with `ang_vld` high, `uvw` is 3'b000.
- R2: `uvw` is registered. It takes a new value only at the clock edge that samples `ang_vld` high, and it keeps its value through every cycle in which `ang_vld` is low.
- R3: With `pole_sel` = 2'b00 (two poles), the electrical angle equals the input angle. `uvw` (bit 2 = U, bit 1 = V, bit 0 = W) follows the electrical angle E as follows:
  - E < 683: 100
  - E < 1365: 110
  - E < 2048: 010
  - E < 2731: 011
  - E < 3413: 001
  - otherwise: 101
- R4: With `pole_sel` = 2'b01 (four poles), the sector table of R3 applies to E = (2·angle) mod 4096, so the sequence runs twice per turn.
- R5: With `pole_sel` = 2'b10 (eight poles), the sector table of R3 applies to E = (4·angle) mod 4096, so the sequence runs four times per turn.
- R6: `pole_sel` = 2'b11 gives the same outputs as 2'b00.
- R7: After the first valid sample, `uvw` is always one of the six sector codes: one or two lines high, never 000 or 111.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ang_in | input | 12 | Absolute mechanical angle, full scale = one turn |
| ang_vld | input | 1 | Angle sample valid |
| pole_sel | input | 2 | Pole count: 00 = 2, 01 = 4, 10 = 8, 11 = 2 |
| uvw | output | 3 | Commutation lines {U,V,W} |

## Verification
Every result is due one clock after the edge that samples `ang_vld` high. The angle is scaled and its sector found combinationally, and the only register on the path is the state register. The bench drives its inputs on the falling edge and takes them back to invalid after one rising edge. It then compares `uvw` at the next falling edge, half a period after the register has updated. Checks with valid held low sample at the same point and expect the previous value.

// File: rtl/mcg_pkg.sv
package mcg_pkg;

    // Sector state of the six-step sequence, plus the idle state used before lock
    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_S0   = 3'd1,
        ST_S1   = 3'd2,
        ST_S2   = 3'd3,
        ST_S3   = 3'd4,
        ST_S4   = 3'd5,
        ST_S5   = 3'd6
    } step_t;

    // Pole selection codes
    localparam logic [1:0] POLE_2 = 2'b00;
    localparam logic [1:0] POLE_4 = 2'b01;
    localparam logic [1:0] POLE_8 = 2'b10;

    // Rounded lower edge of sector k (k = 1..5) for a w-bit full circle
    function automatic int sector_bound(input int k, input int w);
        return (2 * k * (1 << w) + 6) / 12;
    endfunction

endpackage

// File: rtl/mcg_elec_angle.sv
module mcg_elec_angle #(
    parameter int ANGLE_W = 12,
    parameter int MAX_SHIFT = 2
) (
    input  logic [ANGLE_W-1:0] mech_ang,
    input  logic [1:0]         pole_sel,
    output logic [ANGLE_W-1:0] elec_ang
);
    localparam int WIDE_W = ANGLE_W + MAX_SHIFT;

    logic [1:0]        shamt;
    logic [WIDE_W-1:0] wide;

    // Pole code to shift amount; the unused code falls back to two poles
    always_comb begin
        unique case (pole_sel)
            mcg_pkg::POLE_4: shamt = 2'd1;
            mcg_pkg::POLE_8: shamt = 2'd2;
            default:         shamt = 2'd0;
        endcase
    end

    assign wide     = {{MAX_SHIFT{1'b0}}, mech_ang} << shamt;
    assign elec_ang = wide[ANGLE_W-1:0];

endmodule

// File: rtl/mcg_sector_find.sv
module mcg_sector_find #(
    parameter int ANGLE_W = 12
) (
    input  logic [ANGLE_W-1:0] elec_ang,
    output logic [2:0]         sector
);
    localparam int N_EDGES = 5;

    logic [N_EDGES-1:0] above;

    // One comparator per interior sector edge
    for (genvar k = 0; k < N_EDGES; k++) begin : g_edge
        localparam logic [ANGLE_W-1:0] BND =
            ANGLE_W'(mcg_pkg::sector_bound(k + 1, ANGLE_W));
        assign above[k] = (elec_ang >= BND);
    end

    // Thermometer code to sector index
    always_comb begin
        sector = 3'd0;
        for (int k = 0; k < N_EDGES; k++) begin
            sector = sector + {2'b00, above[k]};
        end
    end

endmodule

// File: rtl/mcg_step_fsm.sv
module mcg_step_fsm (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       smp_vld,
    input  logic [2:0] sector,
    output logic [2:0] uvw
);
    import mcg_pkg::*;

    step_t state_q, state_d, target;

    // Sector index to its state
    always_comb begin
        unique case (sector)
            3'd0:    target = ST_S0;
            3'd1:    target = ST_S1;
            3'd2:    target = ST_S2;
            3'd3:    target = ST_S3;
            3'd4:    target = ST_S4;
            default: target = ST_S5;
        endcase
    end

    // first-lock and step on a valid sample, hold otherwise
    always_comb begin
        state_d = state_q;
        if (smp_vld) begin
            state_d = target;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Output decode from the registered state
    always_comb begin
        unique case (state_q)
            ST_S0:   uvw = 3'b100;
            ST_S1:   uvw = 3'b110;
            ST_S2:   uvw = 3'b010;
            ST_S3:   uvw = 3'b011;
            ST_S4:   uvw = 3'b001;
            ST_S5:   uvw = 3'b101;
            default: uvw = 3'b000;
        endcase
    end

endmodule

// File: rtl/mcg_commutator.sv
module mcg_commutator #(
    parameter int ANGLE_W = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ANGLE_W-1:0] ang_in,
    input  logic               ang_vld,
    input  logic [1:0]         pole_sel,
    output logic [2:0]         uvw
);
    logic [ANGLE_W-1:0] elec_ang;
    logic [2:0]         sector;

    mcg_elec_angle #(.ANGLE_W(ANGLE_W), .MAX_SHIFT(2)) u_scale (
        .mech_ang (ang_in),
        .pole_sel (pole_sel),
        .elec_ang (elec_ang)
    );

    mcg_sector_find #(.ANGLE_W(ANGLE_W)) u_sector (
        .elec_ang (elec_ang),
        .sector   (sector)
    );

    mcg_step_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .smp_vld (ang_vld),
        .sector  (sector),
        .uvw     (uvw)
    );

endmodule

// File: rtl/mcg_commutator_chk.sv
module mcg_commutator_chk #(
    parameter int ANGLE_W = 12
) (
    input logic               clk,
    input logic               rst_n,
    input logic [ANGLE_W-1:0] ang_in,
    input logic               ang_vld,
    input logic [1:0]         pole_sel,
    input logic [2:0]         uvw
);
    logic locked;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) locked <= 1'b0;
        else if (ang_vld) locked <= 1'b1;
    end

    // R1
    idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !locked |-> (uvw == 3'b000));

    // R2
    hold_when_invalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ang_vld |=> $stable(uvw));

    // R7
    legal_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        locked |-> ($countones(uvw) == 1 || $countones(uvw) == 2));

    // R3
    two_pole_first_sector_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ang_vld && pole_sel == 2'b00 && ang_in < 683) |=> (uvw == 3'b100));

    // R4
    four_pole_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ang_vld && pole_sel == 2'b01 && ang_in >= 2048 && ang_in < 2390)
        |=> (uvw == 3'b100));

    // R5
    eight_pole_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ang_vld && pole_sel == 2'b10 && ang_in >= 1024 && ang_in < 1195)
        |=> (uvw == 3'b100));

    // R6
    spare_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ang_vld && pole_sel == 2'b11 && ang_in >= 3413) |=> (uvw == 3'b101));

endmodule

bind mcg_commutator mcg_commutator_chk #(.ANGLE_W(ANGLE_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ang_in   (ang_in),
    .ang_vld  (ang_vld),
    .pole_sel (pole_sel),
    .uvw      (uvw)
);

// File: tb/mcg_commutator_test.sv
module mcg_commutator_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] ang_in = '0;
    logic        ang_vld = 1'b0;
    logic [1:0]  pole_sel = 2'b00;
    logic [2:0]  uvw;

    int n_chk = 0;
    int n_bad = 0;
    logic [2:0] last_uvw = 3'b000;
    bit done = 0;

    always #5 clk = ~clk;

    mcg_commutator uut (
        .clk(clk), .rst_n(rst_n), .ang_in(ang_in),
        .ang_vld(ang_vld), .pole_sel(pole_sel), .uvw(uvw)
    );

    function automatic logic [2:0] model(input logic [11:0] a, input logic [1:0] p);
        int e;
        int sh;
        sh = (p == 2'b01) ? 1 : (p == 2'b10) ? 2 : 0;
        e = (int'(a) << sh) % 4096;
        if (e < 683)       return 3'b100;
        else if (e < 1365) return 3'b110;
        else if (e < 2048) return 3'b010;
        else if (e < 2731) return 3'b011;
        else if (e < 3413) return 3'b001;
        else               return 3'b101;
    endfunction

    task automatic check(input string req, input logic [2:0] got, input logic [2:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: uvw=%b expected %b", req, got, exp);
        end
    endtask

    // Drive at falling edge, check one falling edge later
    task automatic sample(input string req, input logic [11:0] a,
                          input logic [1:0] p, input logic v);
        logic [2:0] exp;
        @(negedge clk);
        ang_in = a; pole_sel = p; ang_vld = v;
        exp = v ? model(a, p) : last_uvw;
        @(negedge clk);
        ang_vld = 1'b0;
        check(req, uvw, exp);
        if (v && ($countones(uvw) < 1 || $countones(uvw) > 2)) begin
            n_bad++;
            $display("FAIL R7: uvw=%b expected one or two lines high", uvw);
        end
        if (v) n_chk++;
        last_uvw = exp;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: run=expired expected=finished");
        finish_run();
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        check("R1 reset", uvw, 3'b000);
        rst_n = 1'b1;
        // R1: invalid inputs before lock leave outputs low
        sample("R1 pre-lock", 12'd1500, 2'b00, 1'b0);
        // R3 boundaries, two poles
        sample("R3 0",    12'd0,    2'b00, 1'b1);
        sample("R3 682",  12'd682,  2'b00, 1'b1);
        sample("R3 683",  12'd683,  2'b00, 1'b1);
        sample("R3 1364", 12'd1364, 2'b00, 1'b1);
        sample("R3 1365", 12'd1365, 2'b00, 1'b1);
        sample("R3 2047", 12'd2047, 2'b00, 1'b1);
        sample("R3 2048", 12'd2048, 2'b00, 1'b1);
        sample("R3 2730", 12'd2730, 2'b00, 1'b1);
        sample("R3 2731", 12'd2731, 2'b00, 1'b1);
        sample("R3 3412", 12'd3412, 2'b00, 1'b1);
        sample("R3 3413", 12'd3413, 2'b00, 1'b1);
        sample("R3 4095", 12'd4095, 2'b00, 1'b1);
        // R2: hold while invalid
        sample("R2 hold a", 12'd100,  2'b00, 1'b0);
        sample("R2 hold b", 12'd2500, 2'b10, 1'b0);
        // R4 four poles
        sample("R4 341",  12'd341,  2'b01, 1'b1);
        sample("R4 342",  12'd342,  2'b01, 1'b1);
        sample("R4 2047", 12'd2047, 2'b01, 1'b1);
        sample("R4 2048", 12'd2048, 2'b01, 1'b1);
        sample("R4 3000", 12'd3000, 2'b01, 1'b1);
        // R5 eight poles
        sample("R5 170",  12'd170,  2'b10, 1'b1);
        sample("R5 171",  12'd171,  2'b10, 1'b1);
        sample("R5 1023", 12'd1023, 2'b10, 1'b1);
        sample("R5 1024", 12'd1024, 2'b10, 1'b1);
        sample("R5 3800", 12'd3800, 2'b10, 1'b1);
        // R6 spare code acts as two poles
        sample("R6 700",  12'd700,  2'b11, 1'b1);
        sample("R6 2100", 12'd2100, 2'b11, 1'b1);
        sample("R6 3500", 12'd3500, 2'b11, 1'b1);
        // Random mix covering R2..R7
        for (int i = 0; i < 400; i++) begin
            logic [11:0] a;
            logic [1:0]  p;
            logic        v;
            a = 12'($urandom);
            p = 2'($urandom);
            v = ($urandom % 4) != 0;
            sample(v ? "R3-R6 random" : "R2 random hold", a, p, v);
        end
        finish_run();
    end

endmodule